// File: doc/BRIEF.md
# Multichannel Conversion Result Pointer

This block is the digital back end of a simultaneous-sampling multichannel converter. A rising edge on the convert-start input captures every channel's input value at once, as a bank of track/holds would. The block then works through the enabled channels one at a time, in ascending channel index. Each channel takes a fixed number of clock cycles. When a channel finishes, its result is written into the next free output register. In the same clock edge an active-low end-of-conversion pulse starts, so the pulse's trailing edge can serve directly as a read strobe.

The output registers share one read port. An internal pointer selects the register that the port shows. The first completion of a sequence returns the pointer to slot 0 and every later completion moves it to the newest slot. When an access ends while the pointer sits on the last result of the most recent sequence, the pointer goes back to slot 0. A first-data flag reports whether the pointer is at slot 0. A busy output covers the whole sequence. The per-channel input values are stand-ins for the analog conversion.

Top module: `conv_result_ptr`

## Requirements
- R1: After reset, busy is low, eoc_n is high, dout_oe is low, every output register reads 0 and first_data equals the FIRST_INIT parameter.
- R2: A rising edge of conv_start while idle, with at least one bit of ch_enable set, raises busy at that clock edge. Busy falls at the clock edge where the last enabled channel completes, which is N×CONV_CYC edges after the start edge for N enabled channels.
- R3: Enabled channels are completed in ascending index order, the k-th one (k from 0) at CONV_CYC×(k+1) edges after the start edge. eoc_n goes low at that same edge and stays low for exactly EOC_CYC cycles.
- R4: The word stored for a channel is the value that channel's lane of sample_in held at the start edge (lane i is bits i×W up to i×W+W-1). Later changes of sample_in have no effect on it.
- R5: At the first completion of a sequence the pointer selects slot 0 and first_data goes high. At the k-th completion (k≥1) the pointer selects slot k and first_data goes low.
- R6: An access while the pointer does not change returns the same word. An access that ends with the pointer on any slot other than the last slot of the most recent sequence leaves the pointer where it is.
- R7: At the clock edge after an access ends, if the pointer is on the last slot of the most recent sequence, the pointer returns to slot 0 and first_data goes high. An access counts as ended when the condition "cs_n and rd_n both low" stops holding.
- R8: dout_oe is high exactly while cs_n and rd_n are both low, and dout shows the word in the slot the pointer selects.
- R9: A conv_start rising edge while busy is high, or one with ch_enable all zero, is ignored. It does not change busy, the captured values, the timing or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Convert start; its rising edge launches a sequence |
| ch_enable | input | NCH | Channel enable mask, bit i enables channel i |
| sample_in | input | NCH×W | Stand-in result per channel, lane i at bits i×W |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| dout | output | W | Word in the slot selected by the pointer |
| dout_oe | output | 1 | Output enable for dout (high-impedance when low) |
| busy | output | 1 | High from start until the last enabled channel completes |
| eoc_n | output | 1 | Active-low end-of-conversion pulse, EOC_CYC cycles |
| first_data | output | 1 | High while the pointer selects slot 0 |

## Verification
Most internal faults in this block appear at the ports within one conversion interval. A stuck or mis-reloaded channel timer moves the eoc_n falling edge and busy's fall away from multiples of CONV_CYC. A wrong remaining-channel mask returns a word from the wrong lane at the first read after that completion. A pointer that fails to advance or reset is seen the cycle after the completion or access end: first_data has the wrong level and dout repeats or skips a word. A sequence restarted while busy shows as a busy period longer than the enabled count allows, and as different captured values.

// File: rtl/crp_pkg.sv
package crp_pkg;

    localparam int CRP_MAX_CH = 16;
    localparam int CRP_IW     = 4;

    typedef logic [CRP_IW-1:0] idx_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_st_t;

    typedef struct packed {
        logic fire;
        idx_t chan;
        idx_t slot;
    } done_ev_t;

    function automatic idx_t lowest_set(input logic [CRP_MAX_CH-1:0] m);
        idx_t r;
        r = '0;
        for (int i = CRP_MAX_CH - 1; i >= 0; i--) begin
            if (m[i]) r = idx_t'(i);
        end
        return r;
    endfunction

    function automatic idx_t count_minus_one(input logic [CRP_MAX_CH-1:0] m);
        int n;
        n = 0;
        for (int i = 0; i < CRP_MAX_CH; i++) begin
            n += int'(m[i]);
        end
        return idx_t'(n - 1);
    endfunction

endpackage

// File: rtl/crp_edge.sv
module crp_edge #(
    parameter bit RISING  = 1'b1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic edge_o
);
    logic d_q;

    always_ff @(posedge clk) begin
        if (rst) d_q <= RST_VAL;
        else     d_q <= d;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = d & ~d_q;
        end else begin : g_fall
            assign edge_o = ~d & d_q;
        end
    endgenerate
endmodule

// File: rtl/crp_sequencer.sv
module crp_sequencer
    import crp_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CONV_CYC = 8,
    parameter int EOC_CYC  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_edge,
    input  logic [NCH-1:0] ch_enable,
    output logic           launch,
    output done_ev_t       ev,
    output logic           busy,
    output logic           eoc_n,
    output idx_t           last_slot
);
    localparam int TW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
    localparam int EW = $clog2(EOC_CYC + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(CONV_CYC - 1);

    seq_st_t              st;
    logic [NCH-1:0]       rem;
    logic [TW-1:0]        timer;
    idx_t                 slot_cnt;
    logic [EW-1:0]        eoc_cnt;
    idx_t                 last_q;
    logic [CRP_MAX_CH-1:0] rem_w, en_w, rem_after;
    logic                 is_last;

    always_comb begin
        rem_w = '0;
        rem_w[NCH-1:0] = rem;
        en_w = '0;
        en_w[NCH-1:0] = ch_enable;
        ev.fire = (st == SEQ_CONV) && (timer == '0);
        ev.chan = lowest_set(rem_w);
        ev.slot = slot_cnt;
        rem_after = rem_w & ~(CRP_MAX_CH'(1) << ev.chan);
        is_last = (rem_after == '0);
    end

    assign launch    = (st == SEQ_IDLE) && start_edge && (|ch_enable);
    assign busy      = (st == SEQ_CONV);
    assign eoc_n     = (eoc_cnt == '0);
    assign last_slot = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SEQ_IDLE;
            rem      <= '0;
            timer    <= '0;
            slot_cnt <= '0;
            last_q   <= '0;
        end else if (launch) begin
            st       <= SEQ_CONV;
            rem      <= ch_enable;
            timer    <= T_LOAD;
            slot_cnt <= '0;
            last_q   <= count_minus_one(en_w);
        end else if (ev.fire) begin
            rem      <= rem_after[NCH-1:0];
            slot_cnt <= slot_cnt + idx_t'(1);
            timer    <= T_LOAD;
            if (is_last) st <= SEQ_IDLE;
        end else if (st == SEQ_CONV) begin
            timer <= timer - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               eoc_cnt <= '0;
        else if (ev.fire)      eoc_cnt <= EW'(EOC_CYC);
        else if (eoc_cnt != 0) eoc_cnt <= eoc_cnt - EW'(1);
    end
endmodule

// File: rtl/crp_result_bank.sv
module crp_result_bank
    import crp_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int W          = 12,
    parameter bit FIRST_INIT = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           launch,
    input  logic [NCH*W-1:0] sample_in,
    input  done_ev_t       ev,
    input  logic           rd_end,
    input  idx_t           last_slot,
    output logic [W-1:0]   dout,
    output logic           first_data
);
    logic [W-1:0] lane [NCH];
    logic [W-1:0] hold [NCH];
    logic [W-1:0] slot [NCH];
    logic [W-1:0] hold_sel;
    idx_t         ptr;
    logic         first_q;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_lane
            assign lane[g] = sample_in[g*W +: W];
        end
    endgenerate

    always_comb begin
        hold_sel = '0;
        dout     = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ev.chan == idx_t'(i)) hold_sel = hold[i];
            if (ptr == idx_t'(i))     dout     = slot[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                hold[i] <= '0;
                slot[i] <= '0;
            end
            ptr     <= '0;
            first_q <= FIRST_INIT;
        end else begin
            if (launch) begin
                for (int i = 0; i < NCH; i++) hold[i] <= lane[i];
            end
            if (ev.fire) begin
                for (int i = 0; i < NCH; i++) begin
                    if (ev.slot == idx_t'(i)) slot[i] <= hold_sel;
                end
                ptr     <= ev.slot;
                first_q <= (ev.slot == '0);
            end else if (rd_end && (ptr == last_slot)) begin
                ptr     <= '0;
                first_q <= 1'b1;
            end
        end
    end

    assign first_data = first_q;
endmodule

// File: rtl/conv_result_ptr.sv
module conv_result_ptr
    import crp_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int W          = 12,
    parameter int CONV_CYC   = 8,
    parameter int EOC_CYC    = 2,
    parameter bit FIRST_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic [NCH-1:0]   ch_enable,
    input  logic [NCH*W-1:0] sample_in,
    input  logic             cs_n,
    input  logic             rd_n,
    output logic [W-1:0]     dout,
    output logic             dout_oe,
    output logic             busy,
    output logic             eoc_n,
    output logic             first_data
);
    logic     start_edge;
    logic     rd_active;
    logic     rd_end;
    logic     launch;
    done_ev_t ev;
    idx_t     last_slot;

    assign rd_active = ~cs_n & ~rd_n;
    assign dout_oe   = rd_active;

    crp_edge #(.RISING(1'b1), .RST_VAL(1'b0)) i_start_edge (
        .clk(clk), .rst(rst), .d(conv_start), .edge_o(start_edge)
    );

    crp_edge #(.RISING(1'b0), .RST_VAL(1'b0)) i_read_edge (
        .clk(clk), .rst(rst), .d(rd_active), .edge_o(rd_end)
    );

    crp_sequencer #(.NCH(NCH), .CONV_CYC(CONV_CYC), .EOC_CYC(EOC_CYC)) i_seq (
        .clk(clk), .rst(rst), .start_edge(start_edge), .ch_enable(ch_enable),
        .launch(launch), .ev(ev), .busy(busy), .eoc_n(eoc_n), .last_slot(last_slot)
    );

    crp_result_bank #(.NCH(NCH), .W(W), .FIRST_INIT(FIRST_INIT)) i_bank (
        .clk(clk), .rst(rst), .launch(launch), .sample_in(sample_in), .ev(ev),
        .rd_end(rd_end), .last_slot(last_slot), .dout(dout), .first_data(first_data)
    );
endmodule

// File: rtl/crp_checker.sv
module crp_checker #(
    parameter int NCH      = 4,
    parameter int W        = 12,
    parameter int CONV_CYC = 8,
    parameter int EOC_CYC  = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         conv_start,
    input logic [W-1:0] dout,
    input logic         dout_oe,
    input logic         busy,
    input logic         eoc_n,
    input logic         first_data
);
    int busy_len;
    int eoc_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= 0;
            eoc_low  <= 0;
        end else begin
            busy_len <= busy ? busy_len + 1 : 0;
            eoc_low  <= !eoc_n ? eoc_low + 1 : 0;
        end
    end

    // R2: busy only rises after a convert-start was seen high
    assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(conv_start));

    // R9: an ignored restart cannot stretch busy beyond all channels
    assert_busy_len_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_len < NCH * CONV_CYC));

    // R3: end-of-conversion pulse never longer than EOC_CYC
    assert_eoc_width_R3: assert property (@(posedge clk) disable iff (rst)
        !eoc_n |-> (eoc_low < EOC_CYC));

    // R3: every completion happens inside a busy period
    assert_eoc_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_n) |-> $past(busy));

    // R6: a held access sees a steady word unless a completion occurred
    assert_read_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && $past(dout_oe) && !$fell(eoc_n)) |-> $stable(dout));

    // R5/R7: first_data only rises on a completion or after an access ended
    assert_first_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(first_data) |-> ($fell(eoc_n) || ($past(dout_oe, 2) && !$past(dout_oe))));
endmodule

bind conv_result_ptr crp_checker #(
    .NCH(NCH), .W(W), .CONV_CYC(CONV_CYC), .EOC_CYC(EOC_CYC)
) i_crp_checker (
    .clk(clk), .rst(rst), .conv_start(conv_start), .dout(dout),
    .dout_oe(dout_oe), .busy(busy), .eoc_n(eoc_n), .first_data(first_data)
);

// File: tb/test_conv_result_ptr.sv
module test_conv_result_ptr;
    localparam int NCH = 4;
    localparam int W   = 12;
    localparam int C   = 8;
    localparam int E   = 2;
    localparam bit FI  = 1'b1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             conv_start = 1'b0;
    logic [NCH-1:0]   ch_enable = '0;
    logic [NCH*W-1:0] sample_in = '0;
    logic             cs_n = 1'b1;
    logic             rd_n = 1'b1;
    logic [W-1:0]     dout;
    logic             dout_oe, busy, eoc_n, first_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    conv_result_ptr #(.NCH(NCH), .W(W), .CONV_CYC(C), .EOC_CYC(E), .FIRST_INIT(FI))
    i_conv_result_ptr (
        .clk(clk), .rst(rst), .conv_start(conv_start), .ch_enable(ch_enable),
        .sample_in(sample_in), .cs_n(cs_n), .rd_n(rd_n), .dout(dout),
        .dout_oe(dout_oe), .busy(busy), .eoc_n(eoc_n), .first_data(first_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [NCH-1:0] m);
        int n = 0;
        for (int i = 0; i < NCH; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic int kth_chan(input logic [NCH-1:0] m, input int k);
        int seen = 0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return 0;
    endfunction

    task automatic scramble_inputs();
        for (int i = 0; i < NCH; i++) sample_in[i*W +: W] = W'($urandom);
    endtask

    task automatic run_seq(input logic [NCH-1:0] m, input bit do_reads, input bit restart);
        logic [W-1:0] smp [NCH];
        int n = popc(m);
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            smp[i] = W'($urandom);
            sample_in[i*W +: W] = smp[i];
        end
        ch_enable  = m;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        scramble_inputs();
        repeat (C - 1) @(negedge clk);
        chk("R3 no eoc before first completion", int'(eoc_n), 1);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            chk("R3 eoc low at completion", int'(eoc_n), 0);
            chk("R5 first_data at completion", int'(first_data), (k == 0) ? 1 : 0);
            chk("R2 busy level at completion", int'(busy), (k < n - 1) ? 1 : 0);
            if (do_reads) begin
                cs_n = 1'b0; rd_n = 1'b0;
                #1;
                chk("R8 oe during access", int'(dout_oe), 1);
                chk("R4 word for channel", int'(dout), int'(smp[kth_chan(m, k)]));
            end
            @(negedge clk);
            if (E >= 2) chk("R3 eoc still low", int'(eoc_n), 0);
            if (do_reads) begin
                chk("R6 repeated access same word", int'(dout), int'(smp[kth_chan(m, k)]));
                rd_n = 1'b1; cs_n = 1'b1;
                #1;
                chk("R8 oe after access", int'(dout_oe), 0);
            end
            if (k < n - 1) begin
                for (int j = 2; j <= C; j++) begin
                    @(negedge clk);
                    if (j == E) chk("R3 eoc width", int'(eoc_n), 1);
                    if (restart && k == 0 && j == 3) begin
                        conv_start = 1'b1;
                        scramble_inputs();
                    end
                    if (j == 4) conv_start = 1'b0;
                    if (do_reads && j == C - 1)
                        chk("R6 pointer held between completions", int'(first_data), (k == 0) ? 1 : 0);
                end
            end else begin
                @(negedge clk);
                chk("R3 eoc width last", int'(eoc_n), 1);
                chk("R2 busy clear", int'(busy), 0);
                if (do_reads) begin
                    chk("R7 pointer back at slot 0", int'(first_data), 1);
                    cs_n = 1'b0; rd_n = 1'b0;
                    #1;
                    chk("R7 first word again", int'(dout), int'(smp[kth_chan(m, 0)]));
                    @(negedge clk);
                    rd_n = 1'b1; cs_n = 1'b1;
                end else begin
                    chk("R5 pointer on last slot", int'(first_data), (n == 1) ? 1 : 0);
                    cs_n = 1'b0; rd_n = 1'b0;
                    #1;
                    chk("R6 last word", int'(dout), int'(smp[kth_chan(m, n - 1)]));
                    @(negedge clk);
                    rd_n = 1'b1; cs_n = 1'b1;
                    @(negedge clk);
                    chk("R7 pointer reset after last access", int'(first_data), 1);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 eoc reset", int'(eoc_n), 1);
        chk("R1 first_data reset", int'(first_data), int'(FI));
        chk("R1 oe reset", int'(dout_oe), 0);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk("R1 output registers clear", int'(dout), 0);
        chk("R8 oe with cs and rd low", int'(dout_oe), 1);
        @(negedge clk);
        rd_n = 1'b1;
        #1;
        chk("R8 oe with rd high", int'(dout_oe), 0);
        cs_n = 1'b1;

        // R9: empty mask start ignored
        @(negedge clk);
        ch_enable = '0; conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        chk("R9 empty mask ignored", int'(busy), 0);
        @(negedge clk);
        chk("R9 no eoc for empty mask", int'(eoc_n), 1);

        run_seq(4'b1111, 1'b1, 1'b0);
        run_seq(4'b1000, 1'b1, 1'b0);
        run_seq(4'b0101, 1'b0, 1'b0);
        run_seq(4'b1011, 1'b1, 1'b1);
        run_seq(4'b0110, 1'b0, 1'b1);
        for (int t = 0; t < 24; t++) begin
            run_seq(NCH'($urandom_range(1, (1 << NCH) - 1)), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule